// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Model

This block is a synthesizable I2C target that behaves like a small serial EEPROM. It watches the bus clock and data lines through a synchroniser, recognises START, repeated START and STOP, and answers a single 7-bit device address. A 16-bit pointer is loaded by two pointer bytes, high byte first. The target acknowledges each byte received and shifts out memory bytes when the master reads. Data is returned only by pulling the data line low; the line is never driven high.

Written bytes are collected in a one-page buffer and reach the memory array only when STOP is seen. During a write the pointer advances only inside its 32-byte page, so a long burst wraps to the start of the same page. After a STOP that commits data, a programming timer runs for a set number of clock cycles, and during that time the target does not acknowledge its address. Reads may use the current pointer, or a combined message that writes the pointer and then reads after a repeated START. A sequential read advances the full pointer, crosses page boundaries, and wraps at the end of the array. A master NACK ends a read.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset `sda_pull` is 0 and the byte at array address a holds (a*29 + 11) mod 256.
- R2: An address byte whose upper 7 bits differ from `DEV_ADDR` is not acknowledged. The target leaves the data line released for the rest of that message, including every later byte and any read.
- R3: The address byte is acknowledged when its upper 7 bits match and bit 0 (R/W) is 0, and so is every byte written after it. The first byte after the address byte is pointer bits 15:8 and the second is pointer bits 7:0; later bytes are data. Acknowledge means `sda_pull` is 1 through the ninth clock.
- R4: Written data bytes do not change the array until STOP. A read inside the same transaction, after a repeated START, returns the old content.
- R5: During a write only the low 5 bits of the pointer advance, so bytes written past a page end land at the start of the same 32-byte page.
- R6: A read (R/W bit 1) returns the byte at the pointer, most significant bit first, and then adds 1 to the whole pointer. A sequential read crosses page boundaries and wraps from the last array byte to address 0.
- R7: When the master NACKs a read byte, the target releases the data line and drives nothing until the next START or STOP.
- R8: For `BUSY_CYCLES` clock cycles after a STOP that commits at least one data byte, the target does not acknowledge its own address. After that it acknowledges again.
- R9: A write that carries only the two pointer bytes loads the pointer and starts no busy period.
- R10: A START or STOP at any point, including in the middle of a byte, resets the bit count and the protocol state. A complete message after it is handled normally.
- R11: `sda_pull` is only asserted in response to a falling edge of the synchronised clock, never while that clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume that the master changes the data line only while the bus clock is low, except for START and STOP. They also assume that every bus edge is held for longer than the synchroniser depth plus one cycle, so each clock phase is seen as one clean rise and one clean fall. The bench master spaces every line change six system clocks apart and changes data only in the low phase, apart from its deliberate START and STOP patterns. The full array is swept with a sequential read that wraps at its end, and written values are checked against a model the bench updates at each STOP.

// File: rtl/eepm_pkg.sv
`timescale 1ns/1ps
package eepm_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_DEV,
    PS_PHI,
    PS_PLO,
    PS_WR,
    PS_RD,
    PS_HOLD
  } proto_state_t;

  // Pointer step during a write: only the low page bits advance.
  function automatic logic [15:0] wr_ptr_next(input logic [15:0] p, input int unsigned pbits);
    logic [15:0] mask;
    mask = 16'((32'd1 << pbits) - 32'd1);
    return (p & ~mask) | ((p + 16'd1) & mask);
  endfunction

  // Pointer step during a read: the whole pointer advances.
  function automatic logic [15:0] rd_ptr_next(input logic [15:0] p);
    return p + 16'd1;
  endfunction

  // Contents of the array after reset.
  function automatic logic [7:0] init_byte(input logic [15:0] a);
    return 8'((a * 16'd29) + 16'd11);
  endfunction

endpackage

// File: rtl/eepm_linesync.sv
`timescale 1ns/1ps
module eepm_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eepm_store.sv
`timescale 1ns/1ps
module eepm_store
  import eepm_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int PAGE_AW     = 5,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      buf_we,
  input  logic [PAGE_AW-1:0]        buf_idx,
  input  logic [MEM_AW-PAGE_AW-1:0] buf_page,
  input  logic [7:0]                buf_data,
  input  logic                      commit_req,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic                      busy
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int CW    = $clog2(BUSY_CYCLES + 1);

  logic [7:0]                mem  [DEPTH];
  logic [7:0]                pbuf [PAGE];
  logic [PAGE-1:0]           pvalid;
  logic [MEM_AW-PAGE_AW-1:0] pbase;
  logic [CW-1:0]             bcnt;
  logic                      commit_go;

  assign commit_go = commit_req & (|pvalid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(16'(i));
    end else if (commit_go) begin
      for (int j = 0; j < PAGE; j++)
        if (pvalid[j]) mem[{pbase, PAGE_AW'(j)}] <= pbuf[j];
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid <= '0;
      pbase  <= '0;
    end else if (commit_go) begin
      pvalid <= '0;
    end else if (buf_we) begin
      pvalid[buf_idx] <= 1'b1;
      pbase           <= buf_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             bcnt <= '0;
    else if (commit_go)     bcnt <= CW'(BUSY_CYCLES);
    else if (bcnt != '0)    bcnt <= bcnt - 1'b1;
  end

  assign busy    = (bcnt != '0);
  assign rd_data = mem[rd_addr];

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_req));

  // R9
  no_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && pvalid == '0 && !busy) |=> !busy);

endmodule

// File: rtl/eepm_proto.sv
`timescale 1ns/1ps
module eepm_proto
  import eepm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         MEM_AW   = 8,
  parameter int         PAGE_AW  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_lvl,
  input  logic                      sda_lvl,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_ev,
  input  logic                      stop_ev,
  input  logic [7:0]                rd_data,
  input  logic                      busy,
  output logic                      sda_pull,
  output logic                      buf_we,
  output logic [PAGE_AW-1:0]        buf_idx,
  output logic [MEM_AW-PAGE_AW-1:0] buf_page,
  output logic [7:0]                buf_data,
  output logic                      commit_req,
  output logic [MEM_AW-1:0]         rd_addr
);
  proto_state_t state;
  logic [3:0]   bitcnt;
  logic [7:0]   shreg;
  logic [15:0]  ptr;

  // Named events for the checks below.
  logic edge_ok, byte_done, dev_done, wr_done, addr_hit, recv_state;
  assign edge_ok    = ~start_ev & ~stop_ev;
  assign recv_state = (state == PS_DEV) || (state == PS_PHI) ||
                      (state == PS_PLO) || (state == PS_WR);
  assign byte_done  = edge_ok & scl_fall & recv_state & (bitcnt == 4'd8);
  assign dev_done   = byte_done & (state == PS_DEV);
  assign wr_done    = byte_done & (state == PS_WR);
  assign addr_hit   = (shreg[7:1] == DEV_ADDR);

  assign buf_we     = wr_done;
  assign buf_idx    = ptr[PAGE_AW-1:0];
  assign buf_page   = ptr[MEM_AW-1:PAGE_AW];
  assign buf_data   = shreg;
  assign commit_req = stop_ev;
  assign rd_addr    = ptr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      ptr      <= '0;
    end else if (start_ev) begin
      state    <= PS_DEV;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_ev) begin
      state    <= PS_IDLE;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (scl_rise) begin
      if (recv_state && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_lvl};
        bitcnt <= bitcnt + 4'd1;
      end else if (state == PS_RD) begin
        if (bitcnt < 4'd8)                   bitcnt <= bitcnt + 4'd1;
        else if (bitcnt == 4'd9 && sda_lvl)  state  <= PS_HOLD;
      end
    end else if (scl_fall) begin
      if (recv_state) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          unique case (state)
            PS_DEV: begin
              if (addr_hit && !busy) begin
                sda_pull <= 1'b1;
                state    <= shreg[0] ? PS_RD : PS_PHI;
              end else begin
                state    <= PS_HOLD;
              end
            end
            PS_PHI: begin
              ptr[15:8] <= shreg;
              sda_pull  <= 1'b1;
              state     <= PS_PLO;
            end
            PS_PLO: begin
              ptr[7:0] <= shreg;
              sda_pull <= 1'b1;
              state    <= PS_WR;
            end
            default: begin
              ptr      <= wr_ptr_next(ptr, PAGE_AW);
              sda_pull <= 1'b1;
            end
          endcase
        end else if (bitcnt == 4'd9) begin
          sda_pull <= 1'b0;
          bitcnt   <= '0;
        end
      end else if (state == PS_RD) begin
        if (bitcnt == 4'd9) begin
          shreg    <= rd_data;
          sda_pull <= ~rd_data[7];
          ptr      <= rd_ptr_next(ptr);
          bitcnt   <= '0;
        end else if (bitcnt == 4'd8) begin
          sda_pull <= 1'b0;
          bitcnt   <= 4'd9;
        end else begin
          shreg    <= {shreg[6:0], 1'b0};
          sda_pull <= ~shreg[6];
        end
      end
    end
  end

  // R11
  pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_lvl));

  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !addr_hit) |=> !sda_pull);

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy) |=> !sda_pull);

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (ptr[15:PAGE_AW] == $past(ptr[15:PAGE_AW])));

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_HOLD) |-> !sda_pull);

endmodule

// File: rtl/serial_eeprom_target.sv
`timescale 1ns/1ps
module serial_eeprom_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_AW      = 8,
  parameter int         PAGE_AW     = 5,
  parameter int         BUSY_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);
  localparam int PG_W = MEM_AW - PAGE_AW;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic buf_we, commit_req, busy;
  logic [PAGE_AW-1:0] buf_idx;
  logic [PG_W-1:0]    buf_page;
  logic [7:0]         buf_data, rd_data;
  logic [MEM_AW-1:0]  rd_addr;

  eepm_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eepm_proto #(.DEV_ADDR(DEV_ADDR), .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .rd_data(rd_data), .busy(busy), .sda_pull(sda_pull),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_page(buf_page),
    .buf_data(buf_data), .commit_req(commit_req), .rd_addr(rd_addr)
  );

  eepm_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_page(buf_page), .buf_data(buf_data), .commit_req(commit_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

endmodule

// File: tb/serial_eeprom_target_bench.sv
`timescale 1ns/1ps
module serial_eeprom_target_bench;
  localparam logic [6:0] DEV  = 7'h51;
  localparam int         BUSY = 300;
  localparam int         Q    = 6;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  wire  sda_pull;
  wire  sda_line = m_sda & ~sda_pull;

  always #2.5 clk = ~clk;

  serial_eeprom_target #(.DEV_ADDR(DEV), .MEM_AW(8), .PAGE_AW(5),
                         .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_serial_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; wq(); m_scl = 1'b1; wq(); seen = sda_line; m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  // START, address for write, two pointer bytes; acks checked under R3.
  task automatic load_ptr(input logic [15:0] p);
    logic a;
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk("R3 address ack", a, 1);
    wr_byte(p[15:8], a);     chk("R3 pointer high ack", a, 1);
    wr_byte(p[7:0], a);      chk("R3 pointer low ack", a, 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int k = 0; k < 256; k++) model[k] = 8'((k * 29) + 11);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 sda released after reset", sda_pull, 0);

    // R6 / R1: whole-array sequential read, wrapping past the end.
    load_ptr(16'h0000);
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R6 read address ack", a, 1);
    for (int k = 0; k < 258; k++) begin
      rd_byte(k != 257, d);
      chk($sformatf("R1 R6 sweep byte %0d", k), d, model[k % 256]);
    end
    bus_stop();

    // R9: pointer-only write, no busy period, pointer takes effect.
    load_ptr(16'h0040);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R9 ack right after pointer-only write", a, 1);
    rd_byte(1'b0, d);        chk("R9 current read at loaded pointer", d, model[8'h40]);
    bus_stop();

    // R2: foreign address ignored, for write and read.
    bus_start();
    wr_byte({7'h52, 1'b0}, a); chk("R2 foreign write address nack", a, 0);
    wr_byte(8'h00, a);         chk("R2 later byte nack", a, 0);
    bus_stop();
    bus_start();
    wr_byte({7'h52, 1'b1}, a); chk("R2 foreign read address nack", a, 0);
    rd_byte(1'b0, d);          chk("R2 no data driven", d, 8'hFF);
    bus_stop();

    // R3 / R5: page write wrapping inside the page.
    load_ptr(16'h001C);
    for (int i = 0; i < 6; i++) begin
      wr_byte(8'hC0 + 8'(i), a);
      chk($sformatf("R3 data ack %0d", i), a, 1);
      model[8'((28 + i) % 32)] = 8'hC0 + 8'(i);
    end
    bus_stop();

    // R8: busy right after commit, ready after the timer.
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk("R8 nack while busy", a, 0);
    bus_stop();
    repeat (BUSY + 60) @(negedge clk);
    load_ptr(16'h001C);
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R8 ack after busy", a, 1);
    for (int k = 0; k < 6; k++) begin
      rd_byte(k != 5, d);
      chk($sformatf("R5 page read %0h", 28 + k), d, model[8'(28 + k)]);
    end
    bus_stop();
    load_ptr(16'h0000);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b1, d); chk("R5 wrapped byte at 0", d, 8'hC4);
    rd_byte(1'b0, d); chk("R5 wrapped byte at 1", d, 8'hC5);
    bus_stop();

    // R4: data invisible until STOP.
    load_ptr(16'h0080);
    wr_byte(8'h3C, a); chk("R3 data ack", a, 1);
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'h00, a); wr_byte(8'h80, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R4 read address ack", a, 1);
    rd_byte(1'b0, d);        chk("R4 old data before STOP", d, model[8'h80]);
    bus_stop();
    model[8'h80] = 8'h3C;
    repeat (BUSY + 60) @(negedge clk);
    load_ptr(16'h0080);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R4 new data after STOP", d, 8'h3C);
    bus_stop();

    // R7: master NACK releases the line.
    load_ptr(16'h0090);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R7 byte before nack", d, model[8'h90]);
    rd_byte(1'b0, d); chk("R7 line released after nack", d, 8'hFF);
    chk("R7 no pull after nack", sda_pull, 0);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R6 pointer advanced past nacked byte", d, model[8'h91]);
    bus_stop();

    // R10: restart mid-byte, then STOP mid-byte; pointer now 0x0092.
    bus_start();
    clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b1, a);
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk("R10 ack after restart mid-byte", a, 1);
    wr_byte(8'h00, a);
    clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b1, a); clk_bit(1'b1, a);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R10 ack after stop mid-byte", a, 1);
    rd_byte(1'b0, d);        chk("R10 pointer kept after aborted byte", d, model[8'h92]);
    bus_stop();
    chk("R11 released when idle", sda_pull, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule